// File: doc/BRIEF.md
# Conditional Block State Tracker

This block holds the 8-bit state that governs a short run of up to four conditionally executed instructions placed after an if-then style prefix instruction in a stream that mixes 16-bit and 32-bit instructions. The upper nibble of the state is the base condition code and the lower nibble is the mask. The mask encodes how many slots remain in the block and whether each slot uses the condition or its inverse. The predecode stage shows the first halfword of each instruction with a decode strobe. If the halfword is a prefix instruction, its low byte is loaded into a pending register. A separate advance strobe marks each instruction leaving the stage.

On an advance, a nonzero pending value replaces the current state. If nothing is pending, the current state steps one slot forward. The block drives the current condition and an inside-block flag. For exception entry, it exposes the state split into a 6-bit field and a 2-bit field, which the status register saves. An entry pulse then clears the state for the new mode. On exception return, the two saved fields rebuild the pending value, and the state takes effect on the next advance.

The control is a four-state phase machine. Its states are named by whether the mask is nonzero and whether a pending value is waiting:
- `PH_IDLE`: not in a block and nothing pending.
- `PH_ARMED`: a pending value is waiting, outside a block.
- `PH_BLOCK`: inside a block, nothing pending.
- `PH_BLOCK_ARMED`: inside a block with a pending value.

Transitions are:
- load (decode hit or return fields): IDLE→ARMED and BLOCK→BLOCK_ARMED.
- take (advance with a pending value): ARMED or BLOCK_ARMED→BLOCK.
- step (advance, nothing pending): BLOCK stays in BLOCK, or goes to IDLE when the last mask bit shifts out.
- flush (exception entry or reset): any state → IDLE.

Top module: `cx_block_tracker`

## Requirements
- R1: A synchronous active-high `rst` clears the current and pending state. After reset, `cond_o`=0, `in_blk_o`=0 and both save fields are 0. An advance with nothing pending leaves the state at zero.
- R2: With `dec_i` high, a halfword whose bits 15:8 equal 0xBF and whose bits 3:0 are nonzero is a prefix. Its bits 7:0 (condition in 7:4, mask in 3:0) become the pending state. The current state does not change until the next advance.
- R3: A decoded halfword that is not a prefix (bits 15:8 not 0xBF, or bits 3:0 zero) leaves the pending state unchanged. This is seen at the next advance.
- R4: On an advance with a nonzero pending state, the pending value becomes the current state and the pending register clears. No stepping happens on that advance.
- R5: On an advance with zero pending and a nonzero current state, the mask shifts left by one. The bit shifted out of mask bit 3 becomes condition bit 0, and the mask keeps its low 4 bits.
- R6: If the mask is zero after the shift, the condition is also cleared, so the whole state becomes 0 and the block ends.
- R7: `in_blk_o` is high exactly when current mask bits 3:0 are nonzero. `cond_o` shows current bits 7:4.
- R8: `sv_hi_o` carries current state bits 7:2 and `sv_lo_o` carries bits 1:0, combinationally.
- R9: A `ret_i` pulse sets the pending state to {`ret_hi_i`,`ret_lo_i`}. A rebuilt value of zero does not override stepping.
- R10: An `ent_i` pulse clears the current and pending state at the next edge. The save fields hold the old state during the pulse cycle.
- R11: Priority is `ent_i` over everything, then `ret_i` over `dec_i` for the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_i | input | 1 | Decode strobe qualifying `hw_i` |
| hw_i | input | 16 | First halfword of the decoded instruction |
| adv_i | input | 1 | Advance strobe, one per instruction |
| ent_i | input | 1 | Exception entry: flush state |
| ret_i | input | 1 | Exception return / status write: load pending from fields |
| ret_hi_i | input | 6 | Restored high field (state bits 7:2) |
| ret_lo_i | input | 2 | Restored low field (state bits 1:0) |
| cond_o | output | 4 | Current condition code |
| in_blk_o | output | 1 | Inside a conditional block |
| sv_hi_o | output | 6 | State bits 7:2 for saving |
| sv_lo_o | output | 2 | State bits 1:0 for saving |

## Verification
A decode or return only writes the pending register, so the visible state changes on the edge that ends the first advance after it. Advance, step and flush results show one edge after their strobe, and the save fields follow the current state with no extra delay. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each result is read half a cycle after the edge that produced it. Every pending-only operation is checked twice: once right after, to confirm the visible state has not moved, and again after an advance, to confirm the value that was loaded.

// File: rtl/cxb_pkg.sv
package cxb_pkg;
    localparam int COND_W = 4;
    localparam int MASK_W = 4;
    localparam int ST_W   = COND_W + MASK_W;
    localparam int LO_W   = 2;
    localparam int HI_W   = ST_W - LO_W;
    localparam int HW_W   = 16;
    localparam logic [7:0] PREFIX_OPC = 8'hBF;

    typedef struct packed {
        logic [COND_W-1:0] cnd;
        logic [MASK_W-1:0] msk;
    } blk_st_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARMED,
        PH_BLOCK,
        PH_BLOCK_ARMED
    } phase_t;

    function automatic phase_t classify(blk_st_t cur, blk_st_t pend);
        phase_t p;
        if (cur.msk != '0) p = (pend != '0) ? PH_BLOCK_ARMED : PH_BLOCK;
        else               p = (pend != '0) ? PH_ARMED : PH_IDLE;
        return p;
    endfunction
endpackage

// File: rtl/cxb_prefix_det.sv
module cxb_prefix_det
    import cxb_pkg::*;
#(
    parameter logic [7:0] OPC = PREFIX_OPC
) (
    input  logic            dec_i,
    input  logic [HW_W-1:0] hw_i,
    output logic            hit_o,
    output blk_st_t         ld_o
);
    always_comb begin
        hit_o = dec_i && (hw_i[HW_W-1:HW_W-8] == OPC) && (hw_i[MASK_W-1:0] != '0);
        ld_o  = blk_st_t'(hw_i[ST_W-1:0]);
    end
endmodule

// File: rtl/cxb_stepper.sv
module cxb_stepper
    import cxb_pkg::*;
(
    input  blk_st_t cur_i,
    output blk_st_t nxt_o
);
    logic [MASK_W:0] shl;

    always_comb begin
        shl   = {cur_i.msk, 1'b0};
        nxt_o = '0;
        if (cur_i != '0 && shl[MASK_W-1:0] != '0) begin
            nxt_o.msk = shl[MASK_W-1:0];
            nxt_o.cnd = {cur_i.cnd[COND_W-1:1], shl[MASK_W]};
        end
    end
endmodule

// File: rtl/cxb_pack.sv
module cxb_pack
    import cxb_pkg::*;
(
    input  blk_st_t         st_i,
    output logic [HI_W-1:0] hi_o,
    output logic [LO_W-1:0] lo_o,
    input  logic [HI_W-1:0] hi_i,
    input  logic [LO_W-1:0] lo_i,
    output blk_st_t         unp_o
);
    always_comb begin
        hi_o  = st_i[ST_W-1:LO_W];
        lo_o  = st_i[LO_W-1:0];
        unp_o = blk_st_t'({hi_i, lo_i});
    end
endmodule

// File: rtl/cx_block_tracker.sv
module cx_block_tracker
    import cxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_i,
    input  logic [HW_W-1:0]   hw_i,
    input  logic              adv_i,
    input  logic              ent_i,
    input  logic              ret_i,
    input  logic [HI_W-1:0]   ret_hi_i,
    input  logic [LO_W-1:0]   ret_lo_i,
    output logic [COND_W-1:0] cond_o,
    output logic              in_blk_o,
    output logic [HI_W-1:0]   sv_hi_o,
    output logic [LO_W-1:0]   sv_lo_o
);
    blk_st_t cur_q, pend_q, cur_d, pend_d;
    blk_st_t stepped, ld_val, unp_val;
    phase_t  phase_q, phase_d;
    logic    pfx_hit;

    cxb_prefix_det u_det (
        .dec_i (dec_i),
        .hw_i  (hw_i),
        .hit_o (pfx_hit),
        .ld_o  (ld_val)
    );

    cxb_stepper u_step (
        .cur_i (cur_q),
        .nxt_o (stepped)
    );

    cxb_pack u_pack (
        .st_i  (cur_q),
        .hi_o  (sv_hi_o),
        .lo_o  (sv_lo_o),
        .hi_i  (ret_hi_i),
        .lo_i  (ret_lo_i),
        .unp_o (unp_val)
    );

    // next-state: take / step / load / flush
    always_comb begin
        cur_d  = cur_q;
        pend_d = pend_q;
        if (adv_i) begin
            if (pend_q != '0) begin
                cur_d  = pend_q;
                pend_d = '0;
            end else begin
                cur_d = stepped;
            end
        end
        if (ret_i)        pend_d = unp_val;
        else if (pfx_hit) pend_d = ld_val;
        if (ent_i) begin
            cur_d  = '0;
            pend_d = '0;
        end
        phase_d = classify(cur_d, pend_d);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            pend_q  <= '0;
            phase_q <= PH_IDLE;
        end else begin
            cur_q   <= cur_d;
            pend_q  <= pend_d;
            phase_q <= phase_d;
        end
    end

    // outputs
    always_comb begin
        cond_o = cur_q.cnd;
        unique case (phase_q)
            PH_IDLE:        in_blk_o = 1'b0;
            PH_ARMED:       in_blk_o = 1'b0;
            PH_BLOCK:       in_blk_o = 1'b1;
            PH_BLOCK_ARMED: in_blk_o = 1'b1;
        endcase
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cur_q == '0 && pend_q == '0 && phase_q == PH_IDLE));

    // R3
    ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !pfx_hit && !ret_i && !ent_i && !adv_i) |=> (pend_q == $past(pend_q)));

    // R4
    take_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !ent_i && pend_q != '0) |=> (cur_q == $past(pend_q)));

    // R6
    end_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !ent_i && pend_q == '0 && cur_q.msk[MASK_W-2:0] == '0) |=> (cur_q == '0));

    // R7
    inblk_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.msk != '0) |-> in_blk_o);

    // R10
    entry_chk: assert property (@(posedge clk) disable iff (rst)
        ent_i |=> (cur_q == '0 && pend_q == '0));
endmodule

// File: tb/cx_block_tracker_tb_top.sv
module cx_block_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_i = 1'b0;
    logic [15:0] hw_i = '0;
    logic       adv_i = 1'b0;
    logic       ent_i = 1'b0;
    logic       ret_i = 1'b0;
    logic [5:0] ret_hi_i = '0;
    logic [1:0] ret_lo_i = '0;
    logic [3:0] cond_o;
    logic       in_blk_o;
    logic [5:0] sv_hi_o;
    logic [1:0] sv_lo_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cx_block_tracker dut_i (
        .clk(clk), .rst(rst), .dec_i(dec_i), .hw_i(hw_i), .adv_i(adv_i),
        .ent_i(ent_i), .ret_i(ret_i), .ret_hi_i(ret_hi_i), .ret_lo_i(ret_lo_i),
        .cond_o(cond_o), .in_blk_o(in_blk_o), .sv_hi_o(sv_hi_o), .sv_lo_o(sv_lo_o)
    );

    function automatic logic [7:0] model_step(logic [7:0] s);
        logic [4:0] m;
        if (s == 8'h00) return 8'h00;
        m = {s[3:0], 1'b0};
        if (m[3:0] == 4'h0) return 8'h00;
        return {s[7:5], m[4], m[3:0]};
    endfunction

    task automatic chk_state(logic [7:0] es, string req);
        logic [7:0] got;
        got = {cond_o, in_blk_o ? 4'hF : 4'h0};
        total++;
        if (cond_o !== es[7:4] || in_blk_o !== (es[3:0] != 4'h0) ||
            sv_hi_o !== es[7:2] || sv_lo_o !== es[1:0]) begin
            bad++;
            $display("FAIL %s: got cond=%h inblk=%b hi=%h lo=%h, expected state=%h",
                     req, cond_o, in_blk_o, sv_hi_o, sv_lo_o, es);
        end
    endtask

    // one cycle of stimulus, driven at falling edge, sampled at next falling edge
    task automatic cyc(logic d, logic [15:0] h, logic a, logic e, logic r,
                       logic [5:0] hi, logic [1:0] lo);
        @(negedge clk);
        dec_i = d; hw_i = h; adv_i = a; ent_i = e; ret_i = r;
        ret_hi_i = hi; ret_lo_i = lo;
        @(negedge clk);
        dec_i = 1'b0; adv_i = 1'b0; ent_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic dec(logic [15:0] h);  cyc(1'b1, h, 1'b0, 1'b0, 1'b0, 6'h0, 2'h0); endtask
    task automatic adv();                cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 6'h0, 2'h0); endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_state(8'h00, "R1 after reset");
        adv();
        chk_state(8'h00, "R1 advance idle");
        dec(16'hBF0C); adv();
        do_reset();
        chk_state(8'h00, "R1 reset inside block");
    endtask

    task automatic t_simple();
        dec(16'hBF0C);
        chk_state(8'h00, "R2 pending not visible");
        adv();
        chk_state(8'h0C, "R2 R4 prefix taken");
        adv();
        chk_state(8'h18, "R5 step");
        adv();
        chk_state(8'h00, "R6 block end");
    endtask

    task automatic t_four();
        logic [7:0] exp_s;
        dec(16'hBFA7); adv();
        exp_s = 8'hA7;
        chk_state(exp_s, "R4 load A7");
        for (int i = 0; i < 4; i++) begin
            adv();
            exp_s = model_step(exp_s);
            chk_state(exp_s, "R5 R7 four slot walk");
        end
        chk_state(8'h00, "R6 walk ends at zero");
    endtask

    task automatic t_ignore();
        dec(16'hBF00); adv();
        chk_state(8'h00, "R3 zero mask not prefix");
        dec(16'hBE05); adv();
        chk_state(8'h00, "R3 wrong opcode");
        dec(16'hBF0C); adv();
        dec(16'hAF03); adv();
        chk_state(8'h18, "R3 non-prefix in block");
        adv();
    endtask

    task automatic t_override();
        dec(16'hBF0C); adv();
        dec(16'hBF98); adv();
        chk_state(8'h98, "R4 pending overrides step");
        adv();
        chk_state(8'h00, "R6 single slot ends");
    endtask

    task automatic t_save_restore();
        dec(16'hBFA7); adv();
        chk_state(8'hA7, "R8 save fields");
        @(negedge clk); ent_i = 1'b1;
        #1;
        total++;
        if (sv_hi_o !== 6'h29 || sv_lo_o !== 2'h3) begin
            bad++;
            $display("FAIL R10 fields during entry: got %h/%h expected 29/3", sv_hi_o, sv_lo_o);
        end
        @(negedge clk); ent_i = 1'b0;
        chk_state(8'h00, "R10 entry clears");
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 6'h29, 2'h3);
        chk_state(8'h00, "R9 restore pending only");
        adv();
        chk_state(8'hA7, "R9 restore taken");
        adv(); adv(); adv(); adv();
        chk_state(8'h00, "R9 restored block drains");
    endtask

    task automatic t_prio();
        cyc(1'b1, 16'hBF0C, 1'b0, 1'b0, 1'b1, 6'h26, 2'h0);
        adv();
        chk_state(8'h98, "R11 return beats decode");
        dec(16'hBF0C);
        cyc(1'b0, 16'h0, 1'b1, 1'b1, 1'b1, 6'h29, 2'h3);
        chk_state(8'h00, "R11 entry beats advance and return");
        adv();
        chk_state(8'h00, "R11 entry cleared pending");
        dec(16'hBF0C); adv();
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 6'h00, 2'h0);
        adv();
        chk_state(8'h18, "R9 zero restore does not override");
        adv();
    endtask

    initial begin
        do_reset();
        t_reset();
        t_simple();
        t_four();
        t_ignore();
        t_override();
        t_save_restore();
        t_prio();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule